// File: doc/BRIEF.md
# Two-Plane Fixed-Order Overlay Mixer

This block builds the output picture of a display controller from two layered image sources. A primary layer (foreground 1) and an overlay layer (foreground 0) each occupy a rectangular window inside the visible area. The timing generator supplies the current raster coordinate and an active-area strobe. The block then emits one 24-bit RGB pixel per clock, one cycle later. The overlay always sits above the primary layer. Any visible pixel that neither layer covers takes a programmable background colour.

Each layer has its own enable, origin, size and pixel depth. The depth is either a 16-bit word, read as RGB565 or, with a flag, as RGB555, or a 32-bit word carrying 8-bit R, G and B. A select bit feeds the primary layer from an external scaler stream, which is already 24-bit RGB, in place of its memory stream. A global overlay enable gates both layers.

The block is built around a single registered layer state, `pix_layer`, with four named states: BG (0), FG1 (1), FG0 (2) and BLANK (3).
- Every clock, the next state is chosen from the incoming coordinate.
  - Outside the active area, the state goes to BLANK.
  - Otherwise it goes to FG0 when the overlay window hits, else to FG1 when the primary window hits, else to BG.
- Any state can move to any other state on any clock.
- Reset enters BLANK.

Top module: `ovl_mixer`

## Requirements
- R1: While reset is asserted and on the first clock after it, `pix_valid` is 0, `pix_out` is 0 and `pix_layer` is 3 (BLANK).
- R2: A layer covers the pixel (x, y) when origin_x <= x < origin_x + width and origin_y <= y < origin_y + height. A width or height of zero covers nothing.
- R3: Where both enabled windows cover a pixel, the overlay (foreground 0) is output and `pix_layer` is 2. Otherwise a covered pixel from the primary layer gives `pix_layer` 1.
- R4: With `ovl_en` low, no layer shows. With a layer's own enable low, that layer does not show even inside its window.
- R5: An active pixel that no shown layer covers outputs `bg_color`, and `pix_layer` is 0.
- R6: Depth select 1 reads the word as R = bits 23:16, G = bits 15:8, B = bits 7:0. Bits 31:24 and the RGB555 flag are ignored.
- R7: Depth select 0 without the flag reads bits 15:11 as R, bits 10:5 as G and bits 4:0 as B. Each 5-bit field v widens to {v, v[4:2]} and the 6-bit field g widens to {g, g[5:4]}.
- R8: Depth select 0 with the RGB555 flag reads bits 14:10 as R, bits 9:5 as G and bits 4:0 as B. Each field widens as a 5-bit field, and bit 15 is ignored.
- R9: With `p1_use_scaler` high, the primary layer shows `p1_scl_pix` unchanged, and its memory word and depth settings have no effect.
- R10: Outputs reflect the inputs of the previous clock. An inactive coordinate gives `pix_valid` 0, `pix_out` 0 and `pix_layer` 3, and an active one gives `pix_valid` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_active | input | 1 | Current coordinate lies in the active area |
| disp_x | input | XW | Current column |
| disp_y | input | YW | Current row |
| ovl_en | input | 1 | Global enable for both layers |
| bg_color | input | 24 | Background colour {R,G,B} |
| p1_en | input | 1 | Primary layer enable |
| p1_org_x | input | XW | Primary window origin column |
| p1_org_y | input | YW | Primary window origin row |
| p1_wid | input | XW | Primary window width |
| p1_hgt | input | YW | Primary window height |
| p1_depth | input | 1 | Primary depth: 0 = 16-bit word, 1 = 32-bit word |
| p1_is555 | input | 1 | Primary 16-bit word is RGB555 |
| p1_use_scaler | input | 1 | Primary source: 1 = scaler stream, 0 = memory stream |
| p1_mem_word | input | 32 | Primary memory-stream word |
| p1_scl_pix | input | 24 | Scaler stream pixel {R,G,B} |
| p0_en | input | 1 | Overlay layer enable |
| p0_org_x | input | XW | Overlay window origin column |
| p0_org_y | input | YW | Overlay window origin row |
| p0_wid | input | XW | Overlay window width |
| p0_hgt | input | YW | Overlay window height |
| p0_depth | input | 1 | Overlay depth: 0 = 16-bit word, 1 = 32-bit word |
| p0_is555 | input | 1 | Overlay 16-bit word is RGB555 |
| p0_mem_word | input | 32 | Overlay memory-stream word |
| pix_out | output | 24 | Output pixel {R,G,B} |
| pix_valid | output | 1 | Output pixel is in the active area |
| pix_layer | output | 2 | Source of the output pixel: 0 BG, 1 FG1, 2 FG0, 3 BLANK |

## Verification
Several properties are checked on every cycle:
- the one-clock relation between the active strobe and the valid and blank outputs;
- the overlay winning wherever both window hits are present;
- the background colour whenever the state is BG, or the global enable is low;
- the scaler stream passing through unchanged.

Other behaviour is visible only in the bench's scenarios, which compare every clock against a behavioural model:
- the exact window edges and zero-sized windows;
- the per-layer enables;
- the bit layouts and widening of the three pixel depths;
- the reset state.

// File: rtl/ovl_mix_pkg.sv
package ovl_mix_pkg;
    typedef enum logic [1:0] {
        LAYER_BG    = 2'd0,
        LAYER_FG1   = 2'd1,
        LAYER_FG0   = 2'd2,
        LAYER_BLANK = 2'd3
    } layer_t;

    typedef enum logic {
        DEPTH_16 = 1'b0,
        DEPTH_32 = 1'b1
    } depth_t;

    localparam int RGB_W  = 24;
    localparam int WORD_W = 32;
endpackage

// File: rtl/ovl_win_hit.sv
module ovl_win_hit #(
    parameter int XW = 11,
    parameter int YW = 11
) (
    input  logic          en,
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic [XW-1:0] org_x,
    input  logic [YW-1:0] org_y,
    input  logic [XW-1:0] wid,
    input  logic [YW-1:0] hgt,
    output logic          hit
);
    // One extra bit so that origin + size cannot wrap around.
    logic [XW:0] x_end;
    logic [YW:0] y_end;

    always_comb begin
        x_end = {1'b0, org_x} + {1'b0, wid};
        y_end = {1'b0, org_y} + {1'b0, hgt};
        hit   = en
              && (x >= org_x) && ({1'b0, x} < x_end)
              && (y >= org_y) && ({1'b0, y} < y_end);
    end
endmodule

// File: rtl/ovl_px_expand.sv
module ovl_px_expand
    import ovl_mix_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              depth,
    input  logic              is555,
    output logic [RGB_W-1:0]  rgb
);
    logic [4:0] r5, b5, g5;
    logic [5:0] g6;

    always_comb begin
        r5 = is555 ? word[14:10] : word[15:11];
        g5 = word[9:5];
        g6 = word[10:5];
        b5 = word[4:0];
        unique case (depth_t'(depth))
            DEPTH_32: rgb = word[23:0];
            DEPTH_16: begin
                if (is555)
                    rgb = {r5, r5[4:2], g5, g5[4:2], b5, b5[4:2]};
                else
                    rgb = {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
            end
            default: rgb = '0;
        endcase
    end
endmodule

// File: rtl/ovl_mixer.sv
module ovl_mixer
    import ovl_mix_pkg::*;
#(
    parameter int XW = 11,
    parameter int YW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_active,
    input  logic [XW-1:0]     disp_x,
    input  logic [YW-1:0]     disp_y,
    input  logic              ovl_en,
    input  logic [23:0]       bg_color,
    input  logic              p1_en,
    input  logic [XW-1:0]     p1_org_x,
    input  logic [YW-1:0]     p1_org_y,
    input  logic [XW-1:0]     p1_wid,
    input  logic [YW-1:0]     p1_hgt,
    input  logic              p1_depth,
    input  logic              p1_is555,
    input  logic              p1_use_scaler,
    input  logic [31:0]       p1_mem_word,
    input  logic [23:0]       p1_scl_pix,
    input  logic              p0_en,
    input  logic [XW-1:0]     p0_org_x,
    input  logic [YW-1:0]     p0_org_y,
    input  logic [XW-1:0]     p0_wid,
    input  logic [YW-1:0]     p0_hgt,
    input  logic              p0_depth,
    input  logic              p0_is555,
    input  logic [31:0]       p0_mem_word,
    output logic [23:0]       pix_out,
    output logic              pix_valid,
    output logic [1:0]        pix_layer
);
    logic             hit0, hit1;
    logic [RGB_W-1:0] rgb0, rgb1_mem, rgb1;
    layer_t           layer_d, layer_q;
    logic [RGB_W-1:0] pix_d, pix_q;

    ovl_win_hit #(.XW(XW), .YW(YW)) u_hit0 (
        .en(ovl_en & p0_en), .x(disp_x), .y(disp_y),
        .org_x(p0_org_x), .org_y(p0_org_y), .wid(p0_wid), .hgt(p0_hgt),
        .hit(hit0)
    );

    ovl_win_hit #(.XW(XW), .YW(YW)) u_hit1 (
        .en(ovl_en & p1_en), .x(disp_x), .y(disp_y),
        .org_x(p1_org_x), .org_y(p1_org_y), .wid(p1_wid), .hgt(p1_hgt),
        .hit(hit1)
    );

    ovl_px_expand u_exp0 (
        .word(p0_mem_word), .depth(p0_depth), .is555(p0_is555), .rgb(rgb0)
    );

    ovl_px_expand u_exp1 (
        .word(p1_mem_word), .depth(p1_depth), .is555(p1_is555), .rgb(rgb1_mem)
    );

    // The primary layer's source: the scaler stream or the memory stream.
    assign rgb1 = p1_use_scaler ? p1_scl_pix : rgb1_mem;

    // Next-state selection. The priority order is fixed.
    always_comb begin
        if (!disp_active)
            layer_d = LAYER_BLANK;
        else if (hit0)
            layer_d = LAYER_FG0;
        else if (hit1)
            layer_d = LAYER_FG1;
        else
            layer_d = LAYER_BG;
    end

    // Output value for the chosen state.
    always_comb begin
        unique case (layer_d)
            LAYER_FG0:   pix_d = rgb0;
            LAYER_FG1:   pix_d = rgb1;
            LAYER_BG:    pix_d = bg_color;
            LAYER_BLANK: pix_d = '0;
            default:     pix_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            layer_q <= LAYER_BLANK;
            pix_q   <= '0;
        end else begin
            layer_q <= layer_d;
            pix_q   <= pix_d;
        end
    end

    assign pix_out   = pix_q;
    assign pix_layer = layer_q;
    assign pix_valid = (layer_q != LAYER_BLANK);
endmodule

// File: rtl/ovl_mixer_chk.sv
module ovl_mixer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        disp_active,
    input logic        ovl_en,
    input logic        hit0,
    input logic        hit1,
    input logic        p1_use_scaler,
    input logic [23:0] p1_scl_pix,
    input logic [23:0] bg_color,
    input logic [23:0] pix_out,
    input logic        pix_valid,
    input logic [1:0]  pix_layer
);
    // R10
    blank_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_active |=> (!pix_valid && pix_out == 24'd0 && pix_layer == 2'd3));

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_active |=> pix_valid);

    // R3
    fg0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_active && hit0 && hit1) |=> pix_layer == 2'd2);

    // R4
    global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_active && !ovl_en) |=> (pix_layer == 2'd0 && pix_out == $past(bg_color)));

    // R5
    bg_colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_active && !hit0 && !hit1) |=> pix_out == $past(bg_color));

    // R9
    scaler_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_active && !hit0 && hit1 && p1_use_scaler) |=> pix_out == $past(p1_scl_pix));
endmodule

bind ovl_mixer ovl_mixer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .disp_active(disp_active), .ovl_en(ovl_en),
    .hit0(hit0), .hit1(hit1), .p1_use_scaler(p1_use_scaler),
    .p1_scl_pix(p1_scl_pix), .bg_color(bg_color), .pix_out(pix_out),
    .pix_valid(pix_valid), .pix_layer(pix_layer)
);

// File: tb/ovl_mixer_tb.sv
module ovl_mixer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_active = 1'b0;
    logic [10:0] disp_x = '0, disp_y = '0;
    logic        ovl_en = 1'b0;
    logic [23:0] bg_color = 24'h102030;
    logic        p1_en = 0, p1_depth = 0, p1_is555 = 0, p1_use_scaler = 0;
    logic [10:0] p1_org_x = '0, p1_org_y = '0, p1_wid = '0, p1_hgt = '0;
    logic [31:0] p1_mem_word = '0;
    logic [23:0] p1_scl_pix = '0;
    logic        p0_en = 0, p0_depth = 0, p0_is555 = 0;
    logic [10:0] p0_org_x = '0, p0_org_y = '0, p0_wid = '0, p0_hgt = '0;
    logic [31:0] p0_mem_word = '0;
    logic [23:0] pix_out;
    logic        pix_valid;
    logic [1:0]  pix_layer;

    int n_run = 0, n_fail = 0;
    logic [23:0] exp_pix;
    logic [1:0]  exp_layer;
    logic        exp_valid;

    always #10 clk = ~clk;

    ovl_mixer u_dut (.*);

    function automatic logic [23:0] widen(logic [31:0] w, logic wide, logic f555);
        int r, g, b;
        if (wide) return w[23:0];
        b = int'(w[4:0]);
        if (f555) begin
            r = int'(w[14:10]); g = int'(w[9:5]);
            r = r * 8 + r / 4; g = g * 8 + g / 4;
        end else begin
            r = int'(w[15:11]); g = int'(w[10:5]);
            r = r * 8 + r / 4; g = g * 4 + g / 16;
        end
        b = b * 8 + b / 4;
        return {8'(r), 8'(g), 8'(b)};
    endfunction

    function automatic bit covers(logic en, int ox, int oy, int w, int h);
        int x = int'(disp_x), y = int'(disp_y);
        return ovl_en && en && x >= ox && x < ox + w && y >= oy && y < oy + h;
    endfunction

    task automatic model();
        if (!disp_active) begin
            exp_layer = 2'd3; exp_pix = '0; exp_valid = 0;
        end else if (covers(p0_en, int'(p0_org_x), int'(p0_org_y), int'(p0_wid), int'(p0_hgt))) begin
            exp_layer = 2'd2; exp_pix = widen(p0_mem_word, p0_depth, p0_is555); exp_valid = 1;
        end else if (covers(p1_en, int'(p1_org_x), int'(p1_org_y), int'(p1_wid), int'(p1_hgt))) begin
            exp_layer = 2'd1; exp_valid = 1;
            exp_pix = p1_use_scaler ? p1_scl_pix : widen(p1_mem_word, p1_depth, p1_is555);
        end else begin
            exp_layer = 2'd0; exp_pix = bg_color; exp_valid = 1;
        end
    endtask

    task automatic compare(string req);
        n_run++;
        if (pix_out !== exp_pix || pix_layer !== exp_layer || pix_valid !== exp_valid) begin
            n_fail++;
            $display("FAIL %s: got pix=%h layer=%0d valid=%0b, expected pix=%h layer=%0d valid=%0b",
                     req, pix_out, pix_layer, pix_valid, exp_pix, exp_layer, exp_valid);
        end
    endtask

    // Drive one coordinate, let one clock pass, then compare with the model.
    task automatic step(int x, int y, logic act, string req);
        disp_x = 11'(x); disp_y = 11'(y); disp_active = act;
        model();
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state, checked during reset and on the first clock after it.
        disp_active = 1;
        repeat (3) @(negedge clk);
        exp_pix = '0; exp_layer = 2'd3; exp_valid = 0;
        compare("R1");
        rst_n = 1;
        disp_active = 0;
        @(negedge clk);
        compare("R1");

        // R5: no layer shown, so the background colour appears.
        ovl_en = 1;
        step(3, 3, 1, "R5");
        bg_color = 24'hABCDEF;
        step(700, 400, 1, "R5");

        // R2, R7: primary layer, RGB565, window at (10,5) of size 4x3.
        p1_en = 1; p1_org_x = 10; p1_org_y = 5; p1_wid = 4; p1_hgt = 3;
        p1_depth = 0; p1_is555 = 0; p1_mem_word = 32'hFFFF_F81F;
        for (int y = 4; y <= 8; y++)
            for (int x = 9; x <= 14; x++) step(x, y, 1, "R2");
        p1_mem_word = 32'h0000_8A51; step(10, 5, 1, "R7");
        p1_mem_word = 32'h0000_07E0; step(13, 7, 1, "R7");

        // R8: RGB555 with bit 15 set, which must be ignored.
        p1_is555 = 1; p1_mem_word = 32'h0000_FC1F; step(11, 6, 1, "R8");
        p1_mem_word = 32'h0000_2A95; step(11, 6, 1, "R8");

        // R6: 32-bit word, upper byte and the RGB555 flag ignored.
        p1_depth = 1; p1_mem_word = 32'hC3_123456; step(12, 6, 1, "R6");

        // R3: overlay on top, overlapping the primary window.
        p0_en = 1; p0_org_x = 12; p0_org_y = 6; p0_wid = 5; p0_hgt = 5;
        p0_depth = 1; p0_mem_word = 32'h7F_00FF80;
        for (int x = 9; x <= 18; x++) step(x, 6, 1, "R3");
        p0_depth = 0; p0_is555 = 0; p0_mem_word = 32'h0000_1234; step(13, 7, 1, "R3");

        // R2: a zero width or zero height covers nothing.
        p0_wid = 0; step(12, 6, 1, "R2");
        p0_wid = 5; p0_hgt = 0; step(13, 7, 1, "R2");
        p0_hgt = 5;

        // R4: per-layer enable, then the global enable.
        p0_en = 0; step(13, 7, 1, "R4");
        p1_en = 0; step(11, 6, 1, "R4");
        p0_en = 1; p1_en = 1; ovl_en = 0;
        step(13, 7, 1, "R4"); step(11, 6, 1, "R4");
        ovl_en = 1;

        // R9: primary layer fed by the scaler stream.
        p1_use_scaler = 1; p1_scl_pix = 24'h5A6B7C; p1_mem_word = 32'hFFFF_FFFF;
        step(10, 5, 1, "R9");
        p1_depth = 0; p1_scl_pix = 24'h010203; step(11, 7, 1, "R9");
        step(14, 8, 1, "R9");

        // R10: blanking, and recovery back to active.
        step(11, 6, 0, "R10");
        step(13, 7, 1, "R10");
        step(0, 0, 0, "R10");
        step(0, 0, 1, "R10");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule